// File: doc/BRIEF.md
# DMA Transmit Burst Request Controller

This block takes one frame of a programmed length from a DMA engine and delivers it as a serial-side byte stream. Software first writes the frame length, minus one, into a count register. It then pulses a transmit command. The controller then asks the DMA engine for data in bursts of up to 32 bytes. For each burst it raises a request line and counts the write cycles. It drops the request once the burst's last byte is written. It repeats this until the whole frame sits in a transmit FIFO built from two 32-byte pools.

A new burst is requested only when the FIFO can hold all of it. That means either a whole pool is free, or the bytes still owed fit in the free space. The final burst carries only the remainder, so a 70-byte frame arrives as 32, 32 and 6 bytes. After the last write of the frame is accepted, a one-cycle ready pulse tells software that it may start the next frame. On the output side, bytes leave through a valid/ready handshake. The final byte of the frame carries an end-of-frame flag.

The control is a four-state machine:
- `ST_IDLE`: waits for a command. A command here loads the remaining count and moves to `ST_WAIT_SPACE`.
- `ST_WAIT_SPACE`: moves to `ST_BURST` once the space condition holds.
- `ST_BURST`: holds the request. On the write that closes the burst it returns to `ST_WAIT_SPACE`. If that write is the frame's last byte, it goes to `ST_FINISH` instead.
- `ST_FINISH`: drives the ready pulse for one cycle and then returns to `ST_IDLE`.

A command that arrives in any state other than `ST_IDLE` is dropped and sets a sticky error bit.

Top module: `dma_tx_burst_ctrl`

## Requirements
- R1: The count register holds frame length minus one. A command started with count N moves exactly N+1 bytes through DMA write cycles.
- R2: Each DMA request is served in bursts of 32 write cycles. The last burst of the frame has the remaining (length mod 32, or 32) cycles.
- R3: The request stays high through every write cycle of a burst. It goes low in the cycle after the burst's final write is accepted.
- R4: A request is raised only when at least 32 bytes of the 64-byte FIFO are free, or when the free space covers all bytes still owed. While neither holds, the request stays low.
- R5: The ready output is high for exactly one cycle per frame: the cycle right after the frame's final write is accepted.
- R6: Bytes leave the output stream in the order the DMA wrote them. The end-of-frame flag is 1 on the frame's last byte and 0 on every other byte.
- R7: A transmit command issued while a frame is in progress is ignored, so the running frame is neither restarted nor resized. It sets the error output, which stays at 1 until reset.
- R8: A DMA write strobe given while the request is low is ignored: no byte enters the FIFO.
- R9: A synchronous active-high reset empties the FIFO and drops the request. It also clears the ready and error outputs.
- R10: While the output is valid and not accepted, the data and end-of-frame flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the count register |
| cfg_len_m1 | input | CNT_W | Frame length minus one |
| cmd_xmit | input | 1 | Transmit-frame command pulse |
| dma_req | output | 1 | DMA burst request |
| dma_we | input | 1 | DMA write cycle strobe |
| dma_wdata | input | DATA_W | DMA write data |
| xmit_rdy | output | 1 | One-cycle pulse after the frame's last write |
| cmd_err | output | 1 | Sticky: command issued while busy |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | End-of-frame flag on the output byte |

## Verification
The main function is tried with a table of frame lengths:
- 70 bytes: two full bursts plus a remainder.
- 1 byte: a single-byte frame.
- 32 bytes: exactly one pool.
- 33 bytes: one pool plus one byte.
- 64 bytes: both pools, filled exactly.
- 97 bytes: four bursts, the last of one byte.

Together these separate a correct remainder calculation from off-by-one errors at the pool boundary and at the length-minus-one encoding. A 100-byte frame with the output stalled shows whether the controller waits for a whole pool before asking again. The same run shows whether it ignores a repeated command. Stray DMA strobes with no request pending show whether the FIFO accepts only requested writes.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_SPACE,
        ST_BURST,
        ST_FINISH
    } dtb_state_e;
endpackage

// File: rtl/dtb_pool_fifo.sv
module dtb_pool_fifo #(
    parameter int POOL_BYTES = 32,
    parameter int POOLS      = 2,
    parameter int DATA_W     = 8,
    localparam int DEPTH     = POOL_BYTES * POOLS,
    localparam int AW        = $clog2(DEPTH),
    localparam int LW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [LW-1:0]     free_bytes
);
    logic [DATA_W:0] mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [LW-1:0]   level;
    logic            wr_ok, rd_fire;

    assign wr_ok      = wr_en && (level != LW'(DEPTH));
    assign rd_valid   = (level != '0);
    assign rd_fire    = rd_valid && rd_ready;
    assign rd_data    = mem[rd_ptr][DATA_W-1:0];
    assign rd_last    = mem[rd_ptr][DATA_W];
    assign free_bytes = LW'(DEPTH) - level;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= {wr_last, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok)   wr_ptr <= wr_ptr + AW'(1);
            if (rd_fire) rd_ptr <= rd_ptr + AW'(1);
            unique case ({wr_ok, rd_fire})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/dtb_burst_fsm.sv
module dtb_burst_fsm
    import dtb_pkg::*;
#(
    parameter int POOL_BYTES = 32,
    parameter int CNT_W      = 12,
    parameter int LW         = 7,
    localparam int RW        = CNT_W + 1,
    localparam int BW        = $clog2(POOL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] frame_len_m1,
    input  logic             cmd_xmit,
    input  logic             dma_we,
    input  logic [LW-1:0]    free_bytes,
    output logic             dma_req,
    output logic             xmit_rdy,
    output logic             cmd_err,
    output logic             fifo_wr,
    output logic             fifo_last
);
    dtb_state_e       state, state_nx;
    logic [RW-1:0]    remaining;
    logic [BW-1:0]    beat;
    logic             space_ok, beat_last;
    logic [RW+LW-1:0] free_w, rem_w;

    assign free_w    = {{RW{1'b0}}, free_bytes};
    assign rem_w     = {{LW{1'b0}}, remaining};
    assign space_ok  = (free_bytes >= LW'(POOL_BYTES)) || (free_w >= rem_w);
    assign beat_last = (beat == BW'(POOL_BYTES - 1)) || (remaining == RW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (cmd_xmit) state_nx = ST_WAIT_SPACE;
            ST_WAIT_SPACE: if (space_ok) state_nx = ST_BURST;
            ST_BURST:
                if (dma_we && beat_last)
                    state_nx = (remaining == RW'(1)) ? ST_FINISH : ST_WAIT_SPACE;
            ST_FINISH:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // counters and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            beat      <= '0;
            cmd_err   <= 1'b0;
        end else begin
            if (cmd_xmit && state != ST_IDLE) cmd_err <= 1'b1;
            if (state == ST_IDLE && cmd_xmit) begin
                remaining <= {1'b0, frame_len_m1} + RW'(1);
                beat      <= '0;
            end else if (state == ST_BURST && dma_we) begin
                remaining <= remaining - RW'(1);
                beat      <= beat_last ? '0 : beat + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        dma_req   = 1'b0;
        xmit_rdy  = 1'b0;
        fifo_wr   = 1'b0;
        fifo_last = (remaining == RW'(1));
        unique case (state)
            ST_IDLE:       ;
            ST_WAIT_SPACE: ;
            ST_BURST: begin
                dma_req = 1'b1;
                fifo_wr = dma_we;
            end
            ST_FINISH:     xmit_rdy = 1'b1;
            default:       ;
        endcase
    end
endmodule

// File: rtl/dma_tx_burst_ctrl.sv
module dma_tx_burst_ctrl #(
    parameter int POOL_BYTES = 32,
    parameter int POOLS      = 2,
    parameter int CNT_W      = 12,
    parameter int DATA_W     = 8,
    localparam int LW        = $clog2(POOL_BYTES * POOLS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_len_m1,
    input  logic              cmd_xmit,
    output logic              dma_req,
    input  logic              dma_we,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              xmit_rdy,
    output logic              cmd_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    logic [CNT_W-1:0] len_m1_q;
    logic [LW-1:0]    free_bytes;
    logic             fifo_wr, fifo_last;

    always_ff @(posedge clk) begin
        if (rst)         len_m1_q <= '0;
        else if (cfg_we) len_m1_q <= cfg_len_m1;
    end

    dtb_burst_fsm #(
        .POOL_BYTES(POOL_BYTES),
        .CNT_W     (CNT_W),
        .LW        (LW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_len_m1(len_m1_q),
        .cmd_xmit    (cmd_xmit),
        .dma_we      (dma_we),
        .free_bytes  (free_bytes),
        .dma_req     (dma_req),
        .xmit_rdy    (xmit_rdy),
        .cmd_err     (cmd_err),
        .fifo_wr     (fifo_wr),
        .fifo_last   (fifo_last)
    );

    dtb_pool_fifo #(
        .POOL_BYTES(POOL_BYTES),
        .POOLS     (POOLS),
        .DATA_W    (DATA_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (fifo_wr),
        .wr_data   (dma_wdata),
        .wr_last   (fifo_last),
        .rd_ready  (out_ready),
        .rd_valid  (out_valid),
        .rd_data   (out_data),
        .rd_last   (out_last),
        .free_bytes(free_bytes)
    );
endmodule

// File: rtl/dtb_checker.sv
module dtb_checker #(
    parameter int POOL_BYTES = 32,
    parameter int DATA_W     = 8,
    parameter int LW         = 7,
    localparam int CW        = $clog2(POOL_BYTES + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_req,
    input logic              dma_we,
    input logic              xmit_rdy,
    input logic              cmd_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              fifo_wr,
    input logic [LW-1:0]     free_bytes
);
    logic [CW-1:0] beats;

    always_ff @(posedge clk) begin
        if (rst || !dma_req) beats <= '0;
        else if (dma_we)     beats <= beats + CW'(1);
    end

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
        beats <= CW'(POOL_BYTES)); // R2
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_req) |-> $past(dma_we)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (free_bytes != '0)); // R4
    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
        xmit_rdy |=> !xmit_rdy); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err); // R7
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> dma_req); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10
endmodule

bind dma_tx_burst_ctrl dtb_checker #(
    .POOL_BYTES(POOL_BYTES),
    .DATA_W    (DATA_W),
    .LW        (LW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dma_req   (dma_req),
    .dma_we    (dma_we),
    .xmit_rdy  (xmit_rdy),
    .cmd_err   (cmd_err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .fifo_wr   (fifo_wr),
    .free_bytes(free_bytes)
);

// File: tb/test_dma_tx_burst_ctrl.sv
module test_dma_tx_burst_ctrl;
    localparam int CNT_W = 12;
    localparam int POOL  = 32;
    localparam int NVEC  = 6;
    localparam int FRAME_LENS [NVEC] = '{70, 1, 32, 33, 64, 97};
    localparam int EXP_NB     [NVEC] = '{3, 1, 1, 2, 2, 4};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [CNT_W-1:0] cfg_len_m1 = '0;
    logic             cmd_xmit = 1'b0;
    logic             dma_req;
    logic             dma_we = 1'b0;
    logic [7:0]       dma_wdata = '0;
    logic             xmit_rdy, cmd_err, out_valid, out_last;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;

    int n_chk = 0, n_bad = 0;
    int exp_len = 0, frame_tag = 0;
    int wr_idx = 0, burst_cur = 0, nb = 0, rx_idx = 0;
    int data_bad = 0, last_bad = 0, rdy_pulses = 0;
    int bursts [16];
    bit sink_hold = 1'b0, stray_we = 1'b0, drove_req = 1'b0;

    always #10 clk = ~clk;

    dma_tx_burst_ctrl i_dma_tx_burst_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len_m1(cfg_len_m1),
        .cmd_xmit(cmd_xmit), .dma_req(dma_req), .dma_we(dma_we),
        .dma_wdata(dma_wdata), .xmit_rdy(xmit_rdy), .cmd_err(cmd_err),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 7 + frame_tag * 13 + 5);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // DMA engine and stream sink models, acting at the falling edge
    initial forever begin
        @(negedge clk);
        if (drove_req) begin
            wr_idx++;
            burst_cur++;
        end
        if (!dma_req && burst_cur > 0) begin
            if (nb < 16) bursts[nb] = burst_cur;
            nb++;
            burst_cur = 0;
            if (wr_idx == exp_len)
                chk(xmit_rdy == 1'b1, "R5", "ready after final write", int'(xmit_rdy), 1);
        end
        if (xmit_rdy) rdy_pulses++;
        drove_req = dma_req;
        dma_we    = dma_req || stray_we;
        dma_wdata = pat(wr_idx);
        out_ready = !sink_hold;
        if (out_valid && out_ready) begin
            if (out_data != pat(rx_idx)) data_bad++;
            if (out_last != (rx_idx == exp_len - 1)) last_bad++;
            rx_idx++;
        end
    end

    task automatic start_frame(int len, int tag);
        @(negedge clk);
        frame_tag = tag; exp_len = len;
        wr_idx = 0; burst_cur = 0; nb = 0; rx_idx = 0;
        data_bad = 0; last_bad = 0; rdy_pulses = 0;
        cfg_we = 1'b1; cfg_len_m1 = CNT_W'(len - 1);
        @(negedge clk);
        cfg_we = 1'b0; cmd_xmit = 1'b1;
        @(negedge clk);
        cmd_xmit = 1'b0;
    endtask

    task automatic finish_frame(int len, int exp_nb);
        int rem, k, b;
        while (!(rx_idx == len && wr_idx == len && rdy_pulses >= 1)) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(wr_idx == len, "R1", "DMA write cycles", wr_idx, len);
        chk(nb == exp_nb, "R2", "burst count", nb, exp_nb);
        rem = len; k = 0;
        while (rem > 0 && k < 16) begin
            b = (rem > POOL) ? POOL : rem;
            chk(bursts[k] == b, "R3", "burst length", bursts[k], b);
            rem -= b; k++;
        end
        chk(rdy_pulses == 1, "R5", "ready pulses", rdy_pulses, 1);
        chk(data_bad == 0 && rx_idx == len, "R6", "stream order/bytes", rx_idx - data_bad, len);
        chk(last_bad == 0, "R6", "end-of-frame flag errors", last_bad, 0);
    endtask

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        chk(dma_req == 1'b0 && out_valid == 1'b0, "R9", "idle in reset", int'(dma_req | out_valid), 0);
        chk(xmit_rdy == 1'b0 && cmd_err == 1'b0, "R9", "flags in reset", int'(xmit_rdy | cmd_err), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            start_frame(FRAME_LENS[v], v + 1);
            finish_frame(FRAME_LENS[v], EXP_NB[v]);
        end

        // R8: strobes without a request
        stray_we = 1'b1;
        repeat (5) @(negedge clk);
        stray_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8", "stray writes stored", int'(out_valid), 0);
        chk(dma_req == 1'b0, "R8", "request after stray writes", int'(dma_req), 0);

        // R4 / R10 / R7: stalled output, 100-byte frame
        sink_hold = 1'b1;
        start_frame(100, 9);
        while (wr_idx < 64) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(dma_req == 1'b0, "R4", "request while FIFO full", int'(dma_req), 0);
        chk(wr_idx == 64, "R4", "writes while FIFO full", wr_idx, 64);
        held = out_data;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == held, "R10", "held output byte", int'(out_data), int'(held));
        cmd_xmit = 1'b1;
        @(negedge clk);
        cmd_xmit = 1'b0;
        @(negedge clk);
        chk(cmd_err == 1'b1, "R7", "error after busy command", int'(cmd_err), 1);
        sink_hold = 1'b0;
        finish_frame(100, 4);
        chk(cmd_err == 1'b1, "R7", "error stays set", int'(cmd_err), 1);

        // R9: reset clears the error bit
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_err == 1'b0, "R9", "error cleared by reset", int'(cmd_err), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule